// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns virtual addresses from instruction fetch, load and store requests into physical addresses. A virtual address has a page number in its upper bits and a byte offset in its lower bits. The offset passes through unchanged. The page number selects an entry in a single-level page table that lives in physical memory, starting at the table base held in a register. That register is written from outside, and a write switches the unit to another process's table.

Recent translations are kept in a small, fully associative translation cache that uses round-robin replacement. A request that hits the cache completes without touching memory. A miss reads exactly one table entry through a simple read port, which may take any number of cycles to return data. The unit then checks the entry's present bit and access rights, answers with a physical address or a fault cause, and installs the translation only if the access was legal. Only one request is in flight at a time. The request and response sides both use valid/ready handshakes.

Top module: `addr_xlat`

## Requirements
- R1: A successful translation returns `{ppn, offset}`, where the low OFF_W bits (default 10) equal the request's offset and the upper PPN_W bits (default 3) come from the table entry.
- R2: On a miss the unit drives `mem_req_o` with `mem_addr_o = base + vpn*4` and holds both steady until a `mem_rvalid_i` pulse arrives. Any latency of one cycle or more is accepted.
- R3: A table entry with bit 31 = 0 produces a fault with cause 2'b01 and a zero physical address.
- R4: Entry bits 30:29 encode the rights: 00 read-only, 01 read/write, 10 execute-only, 11 read/write/execute. The access kind is 00 load, 01 store, 10 fetch. A load needs 00, 01 or 11. A store needs 01 or 11. A fetch needs 10 or 11. A violation returns cause 2'b10 and a zero address, whether the entry came from the cache or from memory.
- R5: A request that hits the cache makes no memory read. A miss makes exactly one read.
- R6: A request that faults does not install its translation, so the same page walks memory again on the next request.
- R7: Writing the table base invalidates every cache entry. The next request walks the table at the new base.
- R8: The cache holds ENTRIES translations (default 8) and replaces them round-robin from slot 0. After a flush, the (ENTRIES+1)-th distinct miss evicts the first page installed and leaves the second page resident.
- R9: `req_ready_o` is high only when no translation is outstanding. A response holds `rsp_valid_o` and its data steady until `rsp_ready_i` is high.
- R10: After reset, `req_ready_o` = 1, `rsp_valid_o` = 0, `mem_req_o` = 0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_we_i | input | 1 | Write strobe for the table base register |
| base_wdata_i | input | MEM_AW | New table base address |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_vaddr_i | input | VA_W | Virtual address |
| req_kind_i | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response accepted |
| rsp_paddr_o | output | PA_W | Physical address (zero on fault) |
| rsp_fault_o | output | 1 | Fault flag |
| rsp_cause_o | output | 2 | 01 not present, 10 permission, 00 no fault |
| mem_req_o | output | 1 | Table entry read request |
| mem_addr_o | output | MEM_AW | Byte address of the table entry |
| mem_rvalid_i | input | 1 | Read data valid pulse |
| mem_rdata_i | input | PTE_W | Table entry read data |

## Verification
If a cache entry is stale or wrong, the next request to that page returns a bad frame number or a wrong fault. It can also complete without the expected walk on the memory port, or make a walk that should not happen. All of these show up on the response of that request, two edges after it is accepted. Errors in the replacement pointer or in the flush logic stay hidden until a later request reaches the affected slot or page. For that reason the directed sequences fill the cache, evict entries and rewrite the base, and then probe specific pages. A wrong offset, a wrong entry address, or a response that changes under back-pressure is visible in the same cycle it happens.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_kind_e;

  typedef enum logic [1:0] {
    AR_RO  = 2'b00,
    AR_RW  = 2'b01,
    AR_X   = 2'b10,
    AR_RWX = 2'b11
  } acc_rights_e;

  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_NP   = 2'b01;
  localparam logic [1:0] CAUSE_PERM = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WALK,
    ST_RESP
  } xlat_state_e;
endpackage

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
(
  input  logic [1:0] kind_i,
  input  logic [1:0] rights_i,
  output logic       ok_o
);
  always_comb begin
    ok_o = 1'b0;
    unique case (kind_i)
      ACC_LOAD:  ok_o = (rights_i != AR_X);
      ACC_STORE: ok_o = (rights_i == AR_RW) || (rights_i == AR_RWX);
      ACC_FETCH: ok_o = (rights_i == AR_X)  || (rights_i == AR_RWX);
      default:   ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 5,
  parameter int PPN_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  output logic [1:0]       hit_rights_o,
  input  logic             ins_en_i,
  input  logic [VPN_W-1:0] ins_vpn_i,
  input  logic [PPN_W-1:0] ins_ppn_i,
  input  logic [1:0]       ins_rights_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q    [ENTRIES];
  logic [PPN_W-1:0]   ppn_q    [ENTRIES];
  logic [1:0]         rights_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn_i);
  end

  // at most one entry matches: only misses are installed
  always_comb begin
    hit_ppn_o    = '0;
    hit_rights_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_ppn_o    = hit_ppn_o | ppn_q[i];
        hit_rights_o = hit_rights_o | rights_q[i];
      end
    end
  end
  assign hit_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]    <= '0;
        ppn_q[i]    <= '0;
        rights_q[i] <= '0;
      end
    end else if (flush_i) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (ins_en_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ptr_q == IDX_W'(i)) begin
          valid_q[i]  <= 1'b1;
          vpn_q[i]    <= ins_vpn_i;
          ppn_q[i]    <= ins_ppn_i;
          rights_q[i] <= ins_rights_i;
        end
      end
      ptr_q <= (ptr_q == IDX_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/addr_xlat.sv
module addr_xlat
  import xlat_pkg::*;
#(
  parameter int OFF_W   = 10,
  parameter int VPN_W   = 5,
  parameter int PPN_W   = 3,
  parameter int ENTRIES = 8,
  parameter int MEM_AW  = 32,
  parameter int PTE_W   = 32,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [MEM_AW-1:0] base_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [1:0]        req_kind_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic              rsp_fault_o,
  output logic [1:0]        rsp_cause_o,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i
);
  localparam int PTE_SHIFT = 2;
  localparam int V_BIT     = PTE_W - 1;
  localparam int AR_HI     = PTE_W - 2;
  localparam int AR_LO     = PTE_W - 3;

  xlat_state_e       state_q, state_d;
  logic [MEM_AW-1:0] base_q;
  logic [VA_W-1:0]   vaddr_q;
  logic [1:0]        kind_q;
  logic [PA_W-1:0]   paddr_q;
  logic              fault_q;
  logic [1:0]        cause_q;

  logic [VPN_W-1:0]  vpn;
  logic [OFF_W-1:0]  off;
  logic              hit;
  logic [PPN_W-1:0]  hit_ppn;
  logic [1:0]        hit_rights;
  logic              pte_v;
  logic [1:0]        pte_rights;
  logic [PPN_W-1:0]  pte_ppn;
  logic [1:0]        chk_rights;
  logic [PPN_W-1:0]  res_ppn;
  logic              perm_ok;
  logic              present;
  logic              resolve;
  logic              ins_en;
  logic              unused_pte;

  assign vpn        = vaddr_q[VA_W-1:OFF_W];
  assign off        = vaddr_q[OFF_W-1:0];
  assign pte_v      = mem_rdata_i[V_BIT];
  assign pte_rights = mem_rdata_i[AR_HI:AR_LO];
  assign pte_ppn    = mem_rdata_i[PPN_W-1:0];
  assign unused_pte = ^mem_rdata_i[AR_LO-1:PPN_W];

  xlat_tlb #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) tlb_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (base_we_i),
    .lk_vpn_i     (vpn),
    .hit_o        (hit),
    .hit_ppn_o    (hit_ppn),
    .hit_rights_o (hit_rights),
    .ins_en_i     (ins_en),
    .ins_vpn_i    (vpn),
    .ins_ppn_i    (pte_ppn),
    .ins_rights_i (pte_rights)
  );

  assign chk_rights = (state_q == ST_WALK) ? pte_rights : hit_rights;
  assign res_ppn    = (state_q == ST_WALK) ? pte_ppn : hit_ppn;
  assign present    = (state_q == ST_WALK) ? pte_v : 1'b1;

  xlat_perm perm_i (
    .kind_i   (kind_q),
    .rights_i (chk_rights),
    .ok_o     (perm_ok)
  );

  assign resolve = ((state_q == ST_LOOK) && hit) ||
                   ((state_q == ST_WALK) && mem_rvalid_i);
  assign ins_en  = (state_q == ST_WALK) && mem_rvalid_i && pte_v && perm_ok;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_LOOK;
      ST_LOOK: state_d = hit ? ST_RESP : ST_WALK;
      ST_WALK: if (mem_rvalid_i) state_d = ST_RESP;
      ST_RESP: if (rsp_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      vaddr_q <= '0;
      kind_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      if (base_we_i) base_q <= base_wdata_i;
      if ((state_q == ST_IDLE) && req_valid_i) begin
        vaddr_q <= req_vaddr_i;
        kind_q  <= req_kind_i;
      end
      if (resolve) begin
        if (!present) begin
          fault_q <= 1'b1;
          cause_q <= CAUSE_NP;
          paddr_q <= '0;
        end else if (!perm_ok) begin
          fault_q <= 1'b1;
          cause_q <= CAUSE_PERM;
          paddr_q <= '0;
        end else begin
          fault_q <= 1'b0;
          cause_q <= CAUSE_NONE;
          paddr_q <= {res_ppn, off};
        end
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_paddr_o = paddr_q;
  assign rsp_fault_o = fault_q;
  assign rsp_cause_o = cause_q;
  assign mem_req_o   = (state_q == ST_WALK);
  assign mem_addr_o  = base_q + (MEM_AW'(vpn) << PTE_SHIFT);
endmodule

// File: rtl/addr_xlat_chk.sv
module addr_xlat_chk #(
  parameter int OFF_W  = 10,
  parameter int VA_W   = 15,
  parameter int PA_W   = 13,
  parameter int MEM_AW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [PA_W-1:0]   rsp_paddr_o,
  input logic              rsp_fault_o,
  input logic [1:0]        rsp_cause_o,
  input logic              mem_req_o,
  input logic              mem_rvalid_i,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic [VA_W-1:0]   vaddr_q
);
  // R1
  offset_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_paddr_o[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

  // R2
  walk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R3
  fault_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == '0));

  // R4
  cause_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fault_o ? ($countones(rsp_cause_o) == 1) : (rsp_cause_o == 2'b00)));

  // R9
  single_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_o) |-> !req_ready_o);

  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o) && $stable(rsp_cause_o)));
endmodule

bind addr_xlat addr_xlat_chk #(
  .OFF_W  (OFF_W),
  .VA_W   (VA_W),
  .PA_W   (PA_W),
  .MEM_AW (MEM_AW)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_paddr_o  (rsp_paddr_o),
  .rsp_fault_o  (rsp_fault_o),
  .rsp_cause_o  (rsp_cause_o),
  .mem_req_o    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_addr_o   (mem_addr_o),
  .vaddr_q      (vaddr_q)
);

// File: tb/addr_xlat_tb.sv
module addr_xlat_tb_top;
  localparam int OFF_W = 10;
  localparam int VA_W  = 15;
  localparam int PA_W  = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [PA_W-1:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_checks = 0;
  int n_fail = 0;
  int walk_cnt = 0;
  int mem_lat = 1;
  logic [31:0] last_mem_addr = '0;
  logic [31:0] mem_words [256];
  bit done = 1'b0;

  always #10 clk = ~clk;

  addr_xlat dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .base_we_i    (base_we),
    .base_wdata_i (base_wdata),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_vaddr_i  (req_vaddr),
    .req_kind_i   (req_kind),
    .rsp_valid_o  (rsp_valid),
    .rsp_ready_i  (rsp_ready),
    .rsp_paddr_o  (rsp_paddr),
    .rsp_fault_o  (rsp_fault),
    .rsp_cause_o  (rsp_cause),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata)
  );

  function automatic logic [31:0] mk_pte(bit v, logic [1:0] ar, logic [2:0] ppn);
    return {v, ar, 26'b0, ppn};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        last_mem_addr = mem_addr;
        for (int i = 1; i < mem_lat; i++) @(negedge clk);
        mem_rdata  = mem_words[mem_addr[9:2]];
        mem_rvalid = 1'b1;
        walk_cnt++;
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic set_base(logic [31:0] b);
    @(negedge clk);
    base_we = 1'b1;
    base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic xlat(input logic [VA_W-1:0] va, input logic [1:0] kind,
                      output logic [PA_W-1:0] pa, output logic f,
                      output logic [1:0] c, output int walks);
    int w0;
    int t;
    w0 = walk_cnt;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_kind  = kind;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    if (t >= 200) check(1'b0, "R9", "response timeout", 0, 1);
    pa = rsp_paddr;
    f = rsp_fault;
    c = rsp_cause;
    walks = walk_cnt - w0;
    @(negedge clk);
  endtask

  // one translation with full expectation
  task automatic expect_xlat(string req, logic [4:0] vpn, logic [9:0] off, logic [1:0] kind,
                             bit exp_f, logic [1:0] exp_c, logic [2:0] exp_ppn,
                             int exp_walks, logic [31:0] base);
    logic [PA_W-1:0] pa;
    logic f;
    logic [1:0] c;
    int w;
    logic [PA_W-1:0] exp_pa;
    exp_pa = exp_f ? '0 : {exp_ppn, off};
    xlat({vpn, off}, kind, pa, f, c, w);
    check(f == exp_f, req, "fault", 32'(f), 32'(exp_f));
    check(c == exp_c, req, "cause", 32'(c), 32'(exp_c));
    check(pa == exp_pa, req, "paddr", 32'(pa), 32'(exp_pa));
    check(w == exp_walks, "R5", "walk count", 32'(w), 32'(exp_walks));
    if (exp_walks == 1)
      check(last_mem_addr == base + 32'(vpn) * 4, "R2", "entry address",
            last_mem_addr, base + 32'(vpn) * 4);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R10", "req_ready after reset", 32'(req_ready), 1);
    check(rsp_valid == 1'b0, "R10", "rsp_valid after reset", 32'(rsp_valid), 0);
    check(mem_req == 1'b0, "R10", "mem_req after reset", 32'(mem_req), 0);
  endtask

  task automatic t_basic();
    mem_lat = 1;
    // R1 R2 R5: miss then hits on vpn0 (RW, ppn 5)
    expect_xlat("R1", 5'd0, 10'h123, 2'b00, 1'b0, 2'b00, 3'd5, 1, 32'h0);
    expect_xlat("R1", 5'd0, 10'h3ff, 2'b00, 1'b0, 2'b00, 3'd5, 0, 32'h0);
    expect_xlat("R4", 5'd0, 10'h000, 2'b01, 1'b0, 2'b00, 3'd5, 0, 32'h0);
  endtask

  task automatic t_perm();
    mem_lat = 3;
    // R4: read-only vpn1 ppn2
    expect_xlat("R4", 5'd1, 10'h010, 2'b00, 1'b0, 2'b00, 3'd2, 1, 32'h0);
    expect_xlat("R4", 5'd1, 10'h010, 2'b01, 1'b1, 2'b10, 3'd0, 0, 32'h0);
    // R4: execute-only vpn2 ppn7
    expect_xlat("R4", 5'd2, 10'h2a4, 2'b10, 1'b0, 2'b00, 3'd7, 1, 32'h0);
    expect_xlat("R4", 5'd2, 10'h2a4, 2'b00, 1'b1, 2'b10, 3'd0, 0, 32'h0);
    expect_xlat("R4", 5'd0, 10'h004, 2'b10, 1'b1, 2'b10, 3'd0, 0, 32'h0);
    // R4: rwx vpn4 ppn1
    expect_xlat("R4", 5'd4, 10'h155, 2'b10, 1'b0, 2'b00, 3'd1, 1, 32'h0);
    expect_xlat("R4", 5'd4, 10'h155, 2'b01, 1'b0, 2'b00, 3'd1, 0, 32'h0);
    expect_xlat("R4", 5'd4, 10'h155, 2'b00, 1'b0, 2'b00, 3'd1, 0, 32'h0);
  endtask

  task automatic t_invalid();
    mem_lat = 2;
    // R3 R6: vpn3 not present, walks every time
    expect_xlat("R3", 5'd3, 10'h0ff, 2'b00, 1'b1, 2'b01, 3'd0, 1, 32'h0);
    expect_xlat("R6", 5'd3, 10'h0ff, 2'b00, 1'b1, 2'b01, 3'd0, 1, 32'h0);
    // R6: permission fault on miss is not installed
    set_base(32'h0);
    expect_xlat("R6", 5'd1, 10'h001, 2'b01, 1'b1, 2'b10, 3'd0, 1, 32'h0);
    expect_xlat("R6", 5'd1, 10'h001, 2'b01, 1'b1, 2'b10, 3'd0, 1, 32'h0);
  endtask

  task automatic t_flush();
    mem_lat = 1;
    expect_xlat("R7", 5'd0, 10'h050, 2'b00, 1'b0, 2'b00, 3'd5, 1, 32'h0);
    set_base(32'h100);
    // R7: vpn0 under new table is RO, ppn6
    expect_xlat("R7", 5'd0, 10'h050, 2'b00, 1'b0, 2'b00, 3'd6, 1, 32'h100);
    expect_xlat("R7", 5'd0, 10'h050, 2'b01, 1'b1, 2'b10, 3'd0, 0, 32'h100);
    set_base(32'h0);
    expect_xlat("R7", 5'd0, 10'h050, 2'b01, 1'b0, 2'b00, 3'd5, 1, 32'h0);
  endtask

  task automatic t_round_robin();
    mem_lat = 1;
    set_base(32'h0);
    for (int v = 8; v < 16; v++)
      expect_xlat("R8", 5'(v), 10'h020, 2'b00, 1'b0, 2'b00, 3'(v), 1, 32'h0);
    expect_xlat("R8", 5'd16, 10'h020, 2'b00, 1'b0, 2'b00, 3'd0, 1, 32'h0);
    expect_xlat("R8", 5'd9, 10'h021, 2'b00, 1'b0, 2'b00, 3'd1, 0, 32'h0);
    expect_xlat("R8", 5'd8, 10'h022, 2'b00, 1'b0, 2'b00, 3'd0, 1, 32'h0);
  endtask

  task automatic t_backpressure();
    logic [PA_W-1:0] pa0;
    int t;
    mem_lat = 2;
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {5'd4, 10'h3c0};
    req_kind  = 2'b00;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 50) begin
      @(negedge clk);
      t++;
    end
    pa0 = rsp_paddr;
    check(pa0 == {3'd1, 10'h3c0}, "R9", "paddr under back-pressure", 32'(pa0), 32'({3'd1, 10'h3c0}));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_paddr == pa0, "R9", "response held",
            32'({rsp_valid, rsp_paddr}), 32'({1'b1, pa0}));
      check(req_ready == 1'b0, "R9", "req_ready while pending", 32'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9", "rsp_valid after accept", 32'(rsp_valid), 0);
    check(req_ready == 1'b1, "R9", "req_ready after accept", 32'(req_ready), 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_words[i] = '0;
    mem_words[0] = mk_pte(1'b1, 2'b01, 3'd5);
    mem_words[1] = mk_pte(1'b1, 2'b00, 3'd2);
    mem_words[2] = mk_pte(1'b1, 2'b10, 3'd7);
    mem_words[3] = mk_pte(1'b0, 2'b11, 3'd4);
    mem_words[4] = mk_pte(1'b1, 2'b11, 3'd1);
    for (int v = 8; v <= 16; v++) mem_words[v] = mk_pte(1'b1, 2'b01, 3'(v));
    mem_words[64] = mk_pte(1'b1, 2'b00, 3'd6);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_perm();
    t_invalid();
    t_flush();
    t_round_robin();
    t_backpressure();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule